// File: doc/BRIEF.md
# Prescaled 8-bit Timer with Output Compare

The block is an 8-bit up-counter with a single output-compare channel. The counter advances on a tick enable. A 3-bit clock-select field picks the source of that enable: nothing (the counter is frozen), every clock cycle, or one of six taps of a free-running 10-bit prescaler that divide the clock by 8, 32, 64, 128, 256 or 1024. Each tap gives a one-cycle pulse when its divided count rolls over.

A host reaches four registers through a plain single-cycle write strobe and a combinational read mux. Through them it sets the clock select and two interrupt enables, reads and writes the counter, reads and writes the compare value, and reads the two event flags or clears them. On a tick where the counter holds the compare value, the block raises a compare match. A match sets a sticky flag that can drive an interrupt and toggles a waveform pin. Wrapping from 255 to 0 sets an overflow flag. A host write to the counter suppresses the compare match on the tick that follows it. This lets software reload the counter without a false event.

Top module: `tick_timer8`

## Requirements
- R1: With clock select 0 (ctrl bits [2:0] = 000) the counter never changes unless the host writes it.
- R2: With clock select 1 the counter advances by one on every clock cycle.
- R3: Clock select 2, 3, 4, 5, 6 and 7 advance the counter once every 8, 32, 64, 128, 256 and 1024 clock cycles respectively.
- R4: After reset every register (ctrl at address 0, counter at address 1, compare at address 2, flags at address 3) reads 0. The counter wraps from 255 to 0.
- R5: On a tick where the counter equals the compare value, the match flag (flags bit 0) is set at that same clock edge, and the counter moves on to compare+1.
- R6: A host write to the counter blocks the compare match on the next tick. A write of the compare value itself therefore sets no flag on that tick.
- R7: The waveform output resets low. It toggles once on each compare match that is not blocked, and only then.
- R8: A tick that takes the counter from 255 to 0 sets the overflow flag (flags bit 1) at that edge.
- R9: When a counter write and a tick fall in the same cycle, the written value is loaded and the tick is discarded.
- R10: Writing 1 to a flag bit at address 3 clears that flag. A 0 leaves it unchanged. irq_match is match flag AND ctrl bit 3, and irq_ovf is overflow flag AND ctrl bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 2 | Register select: 0 ctrl, 1 counter, 2 compare, 3 flags |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register (combinational) |
| irq_match | output | 1 | Compare-match interrupt request |
| irq_ovf | output | 1 | Overflow interrupt request |
| wave_out | output | 1 | Waveform pin toggled on compare match |

## Verification
Every compare value from 0 to 255 is swept with the counter preloaded two below it. This separates a match on the correct tick from one a cycle early or late, and the values near 0 also exercise the wrap and overflow path. A subset of compare values is reloaded directly into the counter, which shows whether a write suppresses the next match. Each clock-select code is timed by counting the cycles between two increments, so a wrong tap gives a wrong interval whatever the prescaler phase. A write during raw-clock counting shows whether the write or the tick wins, and selective flag clears show that interrupts are gated per bit.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned CNT_W = 8;
  localparam int unsigned PRE_W = 10;
  localparam int unsigned SEL_W = 3;
  localparam int unsigned NSEL  = 1 << SEL_W;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_CNT  = 2'd1,
    REG_CMP  = 2'd2,
    REG_FLAG = 2'd3
  } reg_sel_e;

  // log2 of the prescaler division picked by a divided-tap select code
  function automatic int unsigned tap_log2(input logic [SEL_W-1:0] sel);
    case (sel)
      3'd2:    return 3;
      3'd3:    return 5;
      3'd4:    return 6;
      3'd5:    return 7;
      3'd6:    return 8;
      3'd7:    return 10;
      default: return 0;
    endcase
  endfunction

  // low bits of the prescaler that must all be ones for a tap to roll over
  function automatic logic [PRE_W-1:0] tap_mask(input logic [SEL_W-1:0] sel);
    logic [PRE_W-1:0] m;
    m = '0;
    for (int unsigned i = 0; i < PRE_W; i++)
      if (i < tap_log2(sel)) m[i] = 1'b1;
    return m;
  endfunction

  function automatic logic [CNT_W-1:0] count_next(input logic [CNT_W-1:0] c);
    return c + 1'b1;
  endfunction
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale
  import tmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  logic [PRE_W-1:0] pre_q;
  logic [NSEL-1:0]  tap;

  always_ff @(posedge clk) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_q + 1'b1;
  end

  for (genvar s = 0; s < NSEL; s++) begin : g_tap
    if (s == 0) begin : g_off
      assign tap[s] = 1'b0;
    end else if (s == 1) begin : g_raw
      assign tap[s] = 1'b1;
    end else begin : g_div
      assign tap[s] = ((pre_q & tap_mask(SEL_W'(s))) == tap_mask(SEL_W'(s)));
    end
  end

  assign tick = tap[sel];
endmodule

// File: rtl/tmr_count.sv
module tmr_count
  import tmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] cnt,
  output logic             blk,
  output logic             advance,
  output logic             wrap_evt
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      blk <= 1'b0;
    end else if (wr) begin
      cnt <= wdata;
      blk <= 1'b1;
    end else if (tick) begin
      cnt <= count_next(cnt);
      blk <= 1'b0;
    end
  end

  assign advance  = tick & ~wr;
  assign wrap_evt = advance & (cnt == {CNT_W{1'b1}});
endmodule

// File: rtl/tmr_compare.sv
module tmr_compare
  import tmr_pkg::*;
(
  input  logic             advance,
  input  logic             blk,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmp,
  output logic             match_evt
);
  assign match_evt = advance & ~blk & (cnt == cmp);
endmodule

// File: rtl/tick_timer8.sv
module tick_timer8
  import tmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [1:0]       bus_addr,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  output logic             irq_match,
  output logic             irq_ovf,
  output logic             wave_out
);
  logic [SEL_W-1:0] cs_q;
  logic             ie_match_q, ie_ovf_q;
  logic [CNT_W-1:0] cmp_q;
  logic             match_flag_q, ovf_flag_q, wave_q;

  // named internal events
  logic             tick, cnt_wr, advance, blk, match_evt, ovf_evt;
  logic [CNT_W-1:0] cnt;
  logic             ctrl_wr, cmp_wr, flag_wr;

  assign ctrl_wr = bus_wr & (bus_addr == REG_CTRL);
  assign cnt_wr  = bus_wr & (bus_addr == REG_CNT);
  assign cmp_wr  = bus_wr & (bus_addr == REG_CMP);
  assign flag_wr = bus_wr & (bus_addr == REG_FLAG);

  tmr_prescale u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .sel   (cs_q),
    .tick  (tick)
  );

  tmr_count u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .wr       (cnt_wr),
    .wdata    (bus_wdata),
    .cnt      (cnt),
    .blk      (blk),
    .advance  (advance),
    .wrap_evt (ovf_evt)
  );

  tmr_compare u_cmp (
    .advance   (advance),
    .blk       (blk),
    .cnt       (cnt),
    .cmp       (cmp_q),
    .match_evt (match_evt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_q       <= '0;
      ie_match_q <= 1'b0;
      ie_ovf_q   <= 1'b0;
      cmp_q      <= '0;
    end else begin
      if (ctrl_wr) begin
        cs_q       <= bus_wdata[SEL_W-1:0];
        ie_match_q <= bus_wdata[3];
        ie_ovf_q   <= bus_wdata[4];
      end
      if (cmp_wr) cmp_q <= bus_wdata;
    end
  end

  // flags: write-one-to-clear, a new event in the same cycle wins
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      match_flag_q <= 1'b0;
      ovf_flag_q   <= 1'b0;
      wave_q       <= 1'b0;
    end else begin
      if (match_evt)                    match_flag_q <= 1'b1;
      else if (flag_wr && bus_wdata[0]) match_flag_q <= 1'b0;
      if (ovf_evt)                      ovf_flag_q   <= 1'b1;
      else if (flag_wr && bus_wdata[1]) ovf_flag_q   <= 1'b0;
      if (match_evt)                    wave_q       <= ~wave_q;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      REG_CTRL: bus_rdata = {{(CNT_W-SEL_W-2){1'b0}}, ie_ovf_q, ie_match_q, cs_q};
      REG_CNT:  bus_rdata = cnt;
      REG_CMP:  bus_rdata = cmp_q;
      default:  bus_rdata = {{(CNT_W-2){1'b0}}, ovf_flag_q, match_flag_q};
    endcase
  end

  assign irq_match = match_flag_q & ie_match_q;
  assign irq_ovf   = ovf_flag_q & ie_ovf_q;
  assign wave_out  = wave_q;
endmodule

// File: rtl/tick_timer8_chk.sv
module tick_timer8_chk
  import tmr_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [SEL_W-1:0] cs,
  input logic             tick,
  input logic             cnt_wr,
  input logic [CNT_W-1:0] wdata,
  input logic [CNT_W-1:0] cnt,
  input logic             match_evt,
  input logic             ovf_evt,
  input logic             match_flag,
  input logic             ovf_flag,
  input logic             wave
);
  a_r1_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (cs == '0 && !cnt_wr) |=> (cnt == $past(cnt)));

  a_r2_raw_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (cs == SEL_W'(1)) |-> tick);

  a_r4_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> (cnt == '0));

  a_r5_match_flag: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt |=> match_flag);

  a_r6_block_next: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> !match_evt);

  a_r7_wave_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt |=> (wave != $past(wave)));

  a_r7_wave_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !match_evt |=> (wave == $past(wave)));

  a_r8_ovf_flag: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> ovf_flag);

  a_r9_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (cnt == $past(wdata)));
endmodule

bind tick_timer8 tick_timer8_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cs         (cs_q),
  .tick       (tick),
  .cnt_wr     (cnt_wr),
  .wdata      (bus_wdata),
  .cnt        (cnt),
  .match_evt  (match_evt),
  .ovf_evt    (ovf_evt),
  .match_flag (match_flag_q),
  .ovf_flag   (ovf_flag_q),
  .wave       (wave_q)
);

// File: tb/tick_timer8_tb.sv
module tick_timer8_tb;
  localparam int CLK_P = 10;
  localparam logic [1:0] A_CTRL = 2'd0, A_CNT = 2'd1, A_CMP = 2'd2, A_FLAG = 2'd3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       irq_match, irq_ovf, wave_out;

  int checks = 0;
  int errors = 0;
  logic exp_wave;

  always #(CLK_P/2) clk = ~clk;

  tick_timer8 u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_match (irq_match),
    .irq_ovf   (irq_ovf),
    .wave_out  (wave_out)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    step();
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  function automatic int div_of(input int sel);
    case (sel)
      1: return 1;
      2: return 8;
      3: return 32;
      4: return 64;
      5: return 128;
      6: return 256;
      default: return 1024;
    endcase
  endfunction

  initial begin
    #(CLK_P * 200000);
    chk(1'b0, "watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v, v0, v1;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R4 / R7: reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      chk(v == 8'd0, "R4 reset register", int'(v), 0);
    end
    chk(wave_out == 1'b0, "R7 wave reset low", int'(wave_out), 0);
    chk(irq_match == 1'b0 && irq_ovf == 1'b0, "R10 irq reset", int'({irq_match, irq_ovf}), 0);

    // R1: stopped counter holds across a full longest prescaler period
    wr(A_CNT, 8'd42);
    repeat (2100) step();
    rd(A_CNT, v);
    chk(v == 8'd42, "R1 stopped counter", int'(v), 42);

    // R2 / R3: interval between increments per clock select
    for (int s = 1; s < 8; s++) begin
      wr(A_CTRL, 8'(s));
      rd(A_CNT, v0);
      n = 0;
      do begin step(); rd(A_CNT, v); n++; end while (v == v0 && n < 3000);
      v1 = v; n = 0;
      do begin step(); rd(A_CNT, v); n++; end while (v == v1 && n < 3000);
      chk(n == div_of(s), (s == 1) ? "R2 raw interval" : "R3 divided interval", n, div_of(s));
      chk(v == 8'(v1 + 1), "R3 single increment", int'(v), int'(8'(v1 + 1)));
    end
    wr(A_CTRL, 8'd0);

    // R9: counter write wins over a same-cycle tick
    wr(A_CTRL, 8'd1);
    wr(A_CNT, 8'd100);
    rd(A_CNT, v);
    chk(v == 8'd100, "R9 write beats tick", int'(v), 100);
    step();
    rd(A_CNT, v);
    chk(v == 8'd101, "R9 counting resumes", int'(v), 101);
    wr(A_CTRL, 8'd0);

    // R8 / R4: overflow at wrap
    wr(A_FLAG, 8'd3);
    wr(A_CMP, 8'd10);
    wr(A_CNT, 8'd254);
    wr(A_CTRL, 8'h11);
    step();
    rd(A_FLAG, v);
    chk(v[1] == 1'b0 && irq_ovf == 1'b0, "R8 no overflow at 255", int'(v[1]), 0);
    step();
    rd(A_CNT, v);
    chk(v == 8'd0, "R4 wrap to zero", int'(v), 0);
    rd(A_FLAG, v);
    chk(v[1] == 1'b1, "R8 overflow flag", int'(v[1]), 1);
    chk(irq_ovf == 1'b1, "R10 overflow irq", int'(irq_ovf), 1);
    wr(A_CTRL, 8'd0);

    // R5 / R6 / R7: sweep every compare value
    exp_wave = wave_out;
    for (int c = 0; c < 256; c++) begin
      wr(A_CTRL, 8'd0);
      wr(A_FLAG, 8'd3);
      wr(A_CMP, 8'(c));
      wr(A_CNT, 8'(c - 2));
      wr(A_CTRL, 8'd1);
      step(); step();
      rd(A_CNT, v);
      chk(v == 8'(c), "R5 counter reaches compare", int'(v), c);
      rd(A_FLAG, v);
      chk(v[0] == 1'b0, "R5 no early match", int'(v[0]), 0);
      step();
      exp_wave = ~exp_wave;
      rd(A_FLAG, v);
      chk(v[0] == 1'b1, "R5 match flag", int'(v[0]), 1);
      rd(A_CNT, v);
      chk(v == 8'(c + 1), "R5 counter past compare", int'(v), int'(8'(c + 1)));
      chk(wave_out == exp_wave, "R7 wave toggles", int'(wave_out), int'(exp_wave));
      if (c % 16 == 3) begin
        wr(A_CTRL, 8'd0);
        wr(A_FLAG, 8'd1);
        wr(A_CNT, 8'(c));
        wr(A_CTRL, 8'd1);
        step();
        rd(A_CNT, v);
        chk(v == 8'(c + 1), "R6 blocked tick advances", int'(v), int'(8'(c + 1)));
        rd(A_FLAG, v);
        chk(v[0] == 1'b0, "R6 match blocked", int'(v[0]), 0);
        chk(wave_out == exp_wave, "R7 no toggle when blocked", int'(wave_out), int'(exp_wave));
        wr(A_CTRL, 8'd0);
        wr(A_CNT, 8'(c - 2));
        wr(A_CTRL, 8'd1);
        step(); step(); step();
        exp_wave = ~exp_wave;
        rd(A_FLAG, v);
        chk(v[0] == 1'b1, "R6 later match not blocked", int'(v[0]), 1);
      end
    end
    wr(A_CTRL, 8'd0);

    // R10: interrupt gating and selective write-one-to-clear
    chk(irq_match == 1'b0, "R10 irq gated by enable", int'(irq_match), 0);
    wr(A_CTRL, 8'h08);
    chk(irq_match == 1'b1, "R10 irq enabled", int'(irq_match), 1);
    wr(A_FLAG, 8'd2);
    rd(A_FLAG, v);
    chk(v[0] == 1'b1 && irq_match == 1'b1, "R10 other bit clear keeps flag", int'(v[0]), 1);
    wr(A_FLAG, 8'd1);
    rd(A_FLAG, v);
    chk(v[0] == 1'b0 && irq_match == 1'b0, "R10 flag cleared", int'(v[0]), 0);
    rd(A_CTRL, v);
    chk(v == 8'h08, "R10 ctrl readback", int'(v), 8);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule